// File: doc/BRIEF.md
# Half-Rate Selective Wakeup Matcher for an Issue Queue

This block is the wakeup half of an out-of-order issue queue. Each slot holds two source operand tags, each with a ready flag. Every cycle the functional units broadcast up to IW result tags, and each tag carries its own valid bit. A waiting operand whose tag equals any valid broadcast tag becomes ready. A slot is reported ready to issue once it is occupied and both of its operands are ready.

Some instructions are known to wait a long time. To save comparator switching, a slot can be allocated as *slow*. A global phase flip-flop alternates between `PH_IDLE` and `PH_ACTIVE`. A slow slot compares only during `PH_ACTIVE` cycles, and its comparators are held off otherwise. A one-cycle broadcast register keeps the tags from the previous cycle. In its active cycle a slow slot matches against both the live tags and the held tags, so a slow slot never loses a wakeup: its ready flags rise at most one cycle later than they would in an ungated queue.

Each slot is a small state machine with three states: `ST_FREE`, `ST_FAST` and `ST_SLOW`. The transitions are:
- `alloc` moves a slot from any state to `ST_FAST` or `ST_SLOW`, chosen by the slow flag.
- `release` moves `ST_FAST` or `ST_SLOW` to `ST_FREE`.
- In every other case the slot holds its state.

The phase machine takes `PH_IDLE -> PH_ACTIVE -> PH_IDLE` on every clock.

Top module: `iqw_wakeup_top`

## Requirements
- R1: After reset, `issue_ready` is all zero. The phase is idle in the first cycle after reset and then alternates every cycle, so cycle k after reset is active when k is odd.
- R2: An allocation (`alloc_valid`=1) writes slot `alloc_idx` with both tags, the initial ready flags and the slow flag, replacing any earlier content. The slot is occupied from the next clock edge.
- R3: At allocation, each operand's ready flag is also set if its tag equals a valid tag broadcast in that same cycle, for both fast and slow slots.
- R4: For an occupied fast slot, a valid match on any of the IW broadcast lanes sets that operand's ready flag at the next edge. `issue_ready[i]` is 1 exactly when slot i is occupied and both of its flags are set.
- R5: A broadcast lane whose `bc_valid` bit is 0 never sets any ready flag.
- R6: An occupied slow slot does not change its ready flags at the edge that ends an idle-phase cycle, unless that slot is allocated or released in the same cycle.
- R7: At the edge that ends an active-phase cycle, a slow slot takes matches from both the current broadcast and the previous cycle's broadcast. After that edge its flags equal those of an ungated queue.
- R8: `release_valid` frees slot `release_idx` at the next edge, which clears its `issue_ready` bit. When allocation and release name the same slot in one cycle, the allocation wins.
- R9: Ready flags are sticky: once set, they stay set until the slot is released or reallocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Write a new instruction into a slot |
| alloc_idx | input | IDXW | Slot to write |
| alloc_tag_l | input | TAGW | Left source tag |
| alloc_tag_r | input | TAGW | Right source tag |
| alloc_rdy_l | input | 1 | Left operand already available |
| alloc_rdy_r | input | 1 | Right operand already available |
| alloc_slow | input | 1 | Slot uses half-rate wakeup |
| bc_valid | input | IW | Per-lane valid of broadcast result tags |
| bc_tag | input | IW x TAGW | Broadcast result tags, one per lane |
| release_valid | input | 1 | Free a slot |
| release_idx | input | IDXW | Slot to free |
| issue_ready | output | ENTRIES | Per-slot ready-to-issue vector |

## Verification
Directed sequences exercise three cases that separate three kinds of fault:
- Allocation with operands already available, allocation with tags matching in the same cycle, and lane-by-lane matches, which expose a dropped or misrouted comparator lane.
- A valid-low lane carrying a matching tag, which catches comparators that ignore the valid bit.
- A slow slot whose producer tags arrive only in an idle-phase cycle. It must stay unready through that edge and become ready at the next one, which shows both the gating and the replay from the held broadcast.

A long random run uses a small tag space, so hits are frequent. It mixes fast and slow slots with allocation and release collisions, and checks every cycle against a model that tracks ungated flags and updates slow slots only on active edges.

// File: rtl/iqw_pkg.sv
package iqw_pkg;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_FAST = 2'd1,
        ST_SLOW = 2'd2
    } iqw_slot_state_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } iqw_phase_e;

endpackage

// File: rtl/iqw_phase_gen.sv
module iqw_phase_gen
    import iqw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic active
);

    iqw_phase_e ph_q, ph_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d = PH_IDLE;
        unique case (ph_q)
            PH_IDLE:   ph_d = PH_ACTIVE;
            PH_ACTIVE: ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    assign active = (ph_q == PH_ACTIVE);

    // R1: phase alternates every cycle
    a_r1_idle_to_active: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> active);
    a_r1_active_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> !active);

endmodule

// File: rtl/iqw_bcast_hold.sv
module iqw_bcast_hold #(
    parameter int IW   = 4,
    parameter int TAGW = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IW-1:0]             in_valid,
    input  logic [IW-1:0][TAGW-1:0]   in_tag,
    output logic [IW-1:0]             held_valid,
    output logic [IW-1:0][TAGW-1:0]   held_tag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_valid <= '0;
            held_tag   <= '0;
        end else begin
            held_valid <= in_valid;
            held_tag   <= in_tag;
        end
    end

endmodule

// File: rtl/iqw_tag_cmp.sv
module iqw_tag_cmp #(
    parameter int IW   = 4,
    parameter int TAGW = 7
) (
    input  logic                      en,
    input  logic [TAGW-1:0]           src_tag,
    input  logic [IW-1:0]             lane_valid,
    input  logic [IW-1:0][TAGW-1:0]   lane_tag,
    output logic                      hit
);

    logic [IW-1:0] lane_hit;

    for (genvar g = 0; g < IW; g++) begin : g_lane
        assign lane_hit[g] = en && lane_valid[g] && (lane_tag[g] == src_tag);
    end

    assign hit = |lane_hit;

endmodule

// File: rtl/iqw_slot.sv
module iqw_slot
    import iqw_pkg::*;
#(
    parameter int IW   = 4,
    parameter int TAGW = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      phase_active,
    input  logic                      alloc_hit,
    input  logic [TAGW-1:0]           alloc_tag_l,
    input  logic [TAGW-1:0]           alloc_tag_r,
    input  logic                      alloc_rdy_l,
    input  logic                      alloc_rdy_r,
    input  logic                      alloc_slow,
    input  logic                      release_hit,
    input  logic [IW-1:0]             cur_valid,
    input  logic [IW-1:0][TAGW-1:0]   cur_tag,
    input  logic [IW-1:0]             held_valid,
    input  logic [IW-1:0][TAGW-1:0]   held_tag,
    output logic                      ready
);

    iqw_slot_state_e st_q, st_d;
    logic [TAGW-1:0] tag_l_q, tag_r_q, tag_l_d, tag_r_d;
    logic            rdy_l_q, rdy_r_q, rdy_l_d, rdy_r_d;

    logic cur_en, held_en;
    logic hit_cur_l, hit_cur_r, hit_held_l, hit_held_r;
    logic hit_new_l, hit_new_r;

    // slot controller: fast slots compare every cycle, slow ones only when active
    always_comb begin
        cur_en  = 1'b0;
        held_en = 1'b0;
        unique case (st_q)
            ST_FREE: begin
                cur_en  = 1'b0;
                held_en = 1'b0;
            end
            ST_FAST: begin
                cur_en  = 1'b1;
                held_en = 1'b0;
            end
            ST_SLOW: begin
                cur_en  = phase_active;
                held_en = phase_active;
            end
            default: begin
                cur_en  = 1'b0;
                held_en = 1'b0;
            end
        endcase
    end

    iqw_tag_cmp #(.IW(IW), .TAGW(TAGW)) u_cmp_cur_l (
        .en(cur_en), .src_tag(tag_l_q), .lane_valid(cur_valid),
        .lane_tag(cur_tag), .hit(hit_cur_l));
    iqw_tag_cmp #(.IW(IW), .TAGW(TAGW)) u_cmp_cur_r (
        .en(cur_en), .src_tag(tag_r_q), .lane_valid(cur_valid),
        .lane_tag(cur_tag), .hit(hit_cur_r));
    iqw_tag_cmp #(.IW(IW), .TAGW(TAGW)) u_cmp_held_l (
        .en(held_en), .src_tag(tag_l_q), .lane_valid(held_valid),
        .lane_tag(held_tag), .hit(hit_held_l));
    iqw_tag_cmp #(.IW(IW), .TAGW(TAGW)) u_cmp_held_r (
        .en(held_en), .src_tag(tag_r_q), .lane_valid(held_valid),
        .lane_tag(held_tag), .hit(hit_held_r));
    iqw_tag_cmp #(.IW(IW), .TAGW(TAGW)) u_cmp_new_l (
        .en(alloc_hit), .src_tag(alloc_tag_l), .lane_valid(cur_valid),
        .lane_tag(cur_tag), .hit(hit_new_l));
    iqw_tag_cmp #(.IW(IW), .TAGW(TAGW)) u_cmp_new_r (
        .en(alloc_hit), .src_tag(alloc_tag_r), .lane_valid(cur_valid),
        .lane_tag(cur_tag), .hit(hit_new_r));

    // next state and flag update
    always_comb begin
        st_d    = st_q;
        tag_l_d = tag_l_q;
        tag_r_d = tag_r_q;
        rdy_l_d = rdy_l_q;
        rdy_r_d = rdy_r_q;
        if (alloc_hit) begin
            st_d    = alloc_slow ? ST_SLOW : ST_FAST;
            tag_l_d = alloc_tag_l;
            tag_r_d = alloc_tag_r;
            rdy_l_d = alloc_rdy_l | hit_new_l;
            rdy_r_d = alloc_rdy_r | hit_new_r;
        end else if (release_hit) begin
            st_d    = ST_FREE;
            rdy_l_d = 1'b0;
            rdy_r_d = 1'b0;
        end else begin
            unique case (st_q)
                ST_FREE: st_d = ST_FREE;
                ST_FAST, ST_SLOW: begin
                    rdy_l_d = rdy_l_q | hit_cur_l | hit_held_l;
                    rdy_r_d = rdy_r_q | hit_cur_r | hit_held_r;
                end
                default: st_d = ST_FREE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_FREE;
            tag_l_q <= '0;
            tag_r_q <= '0;
            rdy_l_q <= 1'b0;
            rdy_r_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            tag_l_q <= tag_l_d;
            tag_r_q <= tag_r_d;
            rdy_l_q <= rdy_l_d;
            rdy_r_q <= rdy_r_d;
        end
    end

    assign ready = (st_q != ST_FREE) && rdy_l_q && rdy_r_q;

    // R6: slow slot holds its flags through an idle-phase edge
    a_r6_slow_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLOW && !phase_active && !alloc_hit && !release_hit)
        |=> ($stable(rdy_l_q) && $stable(rdy_r_q)));

    // R9: a set flag stays set unless the slot is rewritten or freed
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_FREE && rdy_l_q && !alloc_hit && !release_hit) |=> rdy_l_q);

    // R8: release without allocation frees the slot
    a_r8_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (release_hit && !alloc_hit) |=> (st_q == ST_FREE && !ready));

    // R5: with no valid lane now or one cycle ago, flags cannot rise
    a_r5_no_valid_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|cur_valid) && !(|held_valid) && !alloc_hit && !release_hit)
        |=> ($stable(rdy_l_q) && $stable(rdy_r_q)));

endmodule

// File: rtl/iqw_wakeup_top.sv
module iqw_wakeup_top #(
    parameter int ENTRIES = 16,
    parameter int IW      = 4,
    parameter int TAGW    = 7,
    localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_valid,
    input  logic [IDXW-1:0]           alloc_idx,
    input  logic [TAGW-1:0]           alloc_tag_l,
    input  logic [TAGW-1:0]           alloc_tag_r,
    input  logic                      alloc_rdy_l,
    input  logic                      alloc_rdy_r,
    input  logic                      alloc_slow,
    input  logic [IW-1:0]             bc_valid,
    input  logic [IW-1:0][TAGW-1:0]   bc_tag,
    input  logic                      release_valid,
    input  logic [IDXW-1:0]           release_idx,
    output logic [ENTRIES-1:0]        issue_ready
);

    logic                    phase_active;
    logic [IW-1:0]           held_valid;
    logic [IW-1:0][TAGW-1:0] held_tag;

    iqw_phase_gen u_phase (
        .clk(clk), .rst_n(rst_n), .active(phase_active));

    iqw_bcast_hold #(.IW(IW), .TAGW(TAGW)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .in_valid(bc_valid), .in_tag(bc_tag),
        .held_valid(held_valid), .held_tag(held_tag));

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic a_hit, r_hit;
        assign a_hit = alloc_valid   && (alloc_idx   == IDXW'(e));
        assign r_hit = release_valid && (release_idx == IDXW'(e));

        iqw_slot #(.IW(IW), .TAGW(TAGW)) u_slot (
            .clk(clk), .rst_n(rst_n), .phase_active(phase_active),
            .alloc_hit(a_hit),
            .alloc_tag_l(alloc_tag_l), .alloc_tag_r(alloc_tag_r),
            .alloc_rdy_l(alloc_rdy_l), .alloc_rdy_r(alloc_rdy_r),
            .alloc_slow(alloc_slow), .release_hit(r_hit),
            .cur_valid(bc_valid), .cur_tag(bc_tag),
            .held_valid(held_valid), .held_tag(held_tag),
            .ready(issue_ready[e]));
    end

    // R2: allocation with both operands available is ready next cycle
    a_r2_alloc_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_rdy_l && alloc_rdy_r && (32'(alloc_idx) < ENTRIES))
        |=> issue_ready[$past(alloc_idx)]);

endmodule

// File: tb/iqw_wakeup_top_tb.sv
module iqw_wakeup_top_tb;

    localparam int N   = 16;
    localparam int IW  = 4;
    localparam int TW  = 7;
    localparam int IXW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                  alloc_valid, alloc_rdy_l, alloc_rdy_r, alloc_slow;
    logic [IXW-1:0]        alloc_idx, release_idx;
    logic [TW-1:0]         alloc_tag_l, alloc_tag_r;
    logic [IW-1:0]         bc_valid;
    logic [IW-1:0][TW-1:0] bc_tag;
    logic                  release_valid;
    logic [N-1:0]          issue_ready;

    iqw_wakeup_top #(.ENTRIES(N), .IW(IW), .TAGW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
        .alloc_tag_l(alloc_tag_l), .alloc_tag_r(alloc_tag_r),
        .alloc_rdy_l(alloc_rdy_l), .alloc_rdy_r(alloc_rdy_r),
        .alloc_slow(alloc_slow), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .release_valid(release_valid), .release_idx(release_idx),
        .issue_ready(issue_ready));

    typedef struct {
        logic [N-1:0] exp;
        string        req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // staged stimulus
    bit                 s_av, s_rl, s_rr, s_sl, s_dv;
    logic [IXW-1:0]     s_ai, s_di;
    logic [TW-1:0]      s_tl, s_tr;
    logic [IW-1:0]      s_bv;
    logic [TW-1:0]      s_bt [IW];

    // reference model: ungated flags plus visible flags
    bit            m_valid [N];
    bit            m_slow  [N];
    bit            m_ul [N], m_ur [N], m_vl [N], m_vr [N];
    logic [TW-1:0] m_tl [N], m_tr [N];
    bit            m_phase;

    function automatic bit bmatch(logic [TW-1:0] t);
        for (int i = 0; i < IW; i++)
            if (s_bv[i] && s_bt[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void model_step();
        for (int e = 0; e < N; e++) begin
            if (s_av && s_ai == IXW'(e)) begin
                m_valid[e] = 1'b1; m_slow[e] = s_sl;
                m_tl[e] = s_tl; m_tr[e] = s_tr;
                m_ul[e] = s_rl | bmatch(s_tl);
                m_ur[e] = s_rr | bmatch(s_tr);
                m_vl[e] = m_ul[e]; m_vr[e] = m_ur[e];
            end else if (s_dv && s_di == IXW'(e)) begin
                m_valid[e] = 1'b0;
                m_ul[e] = 0; m_ur[e] = 0; m_vl[e] = 0; m_vr[e] = 0;
            end else if (m_valid[e]) begin
                m_ul[e] = m_ul[e] | bmatch(m_tl[e]);
                m_ur[e] = m_ur[e] | bmatch(m_tr[e]);
                if (!m_slow[e] || m_phase) begin
                    m_vl[e] = m_ul[e]; m_vr[e] = m_ur[e];
                end
            end
        end
        m_phase = !m_phase;
    endfunction

    function automatic logic [N-1:0] model_ready();
        logic [N-1:0] v;
        for (int e = 0; e < N; e++) v[e] = m_valid[e] & m_vl[e] & m_vr[e];
        return v;
    endfunction

    function automatic void clear_stage();
        s_av = 0; s_rl = 0; s_rr = 0; s_sl = 0; s_dv = 0;
        s_ai = '0; s_di = '0; s_tl = '0; s_tr = '0; s_bv = '0;
        for (int i = 0; i < IW; i++) s_bt[i] = '0;
    endfunction

    // driver: called at a falling edge, applies one cycle and pushes the expectation
    task automatic cycle();
        sb_item_t it;
        alloc_valid = s_av; alloc_idx = s_ai; alloc_tag_l = s_tl; alloc_tag_r = s_tr;
        alloc_rdy_l = s_rl; alloc_rdy_r = s_rr; alloc_slow = s_sl;
        release_valid = s_dv; release_idx = s_di;
        bc_valid = s_bv;
        for (int i = 0; i < IW; i++) bc_tag[i] = s_bt[i];
        model_step();
        it.exp = model_ready();
        it.req = cur_req;
        sb_q.push_back(it);
        clear_stage();
        @(negedge clk);
    endtask

    // monitor: one sample after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                total++;
                if (issue_ready !== it.exp) begin
                    bad++;
                    $display("FAIL %s: issue_ready=%h expected=%h at %0t",
                             it.req, issue_ready, it.exp, $time);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(400000 * 4);
        total++; bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    task automatic bc(int lane, int tag, bit v);
        s_bv[lane] = v;
        s_bt[lane] = TW'(tag);
    endtask

    task automatic alloc(int idx, int tl, int tr, bit rl, bit rr, bit slow);
        s_av = 1; s_ai = IXW'(idx); s_tl = TW'(tl); s_tr = TW'(tr);
        s_rl = rl; s_rr = rr; s_sl = slow;
    endtask

    initial begin
        clear_stage();
        alloc_valid = 0; alloc_idx = '0; alloc_tag_l = '0; alloc_tag_r = '0;
        alloc_rdy_l = 0; alloc_rdy_r = 0; alloc_slow = 0;
        release_valid = 0; release_idx = '0; bc_valid = '0; bc_tag = '0;
        for (int e = 0; e < N; e++) begin
            m_valid[e] = 0; m_slow[e] = 0; m_ul[e] = 0; m_ur[e] = 0;
            m_vl[e] = 0; m_vr[e] = 0; m_tl[e] = '0; m_tr[e] = '0;
        end
        m_phase = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        total++;
        if (issue_ready !== '0) begin
            bad++;
            $display("FAIL R1: issue_ready=%h expected=%h", issue_ready, {N{1'b0}});
        end

        // cycle 0 (idle phase): R2 allocation with both operands available
        cur_req = "R2"; alloc(0, 5, 6, 1, 1, 0); cycle();
        // R3 allocation hit by same-cycle broadcast
        cur_req = "R3"; alloc(1, 10, 11, 0, 0, 0); bc(2, 10, 1); bc(3, 11, 1); cycle();
        // R4 lane by lane matches
        cur_req = "R4"; alloc(2, 20, 21, 0, 0, 0); cycle();
        cur_req = "R4"; bc(0, 20, 1); cycle();
        // R5 invalid lane carrying the matching tag
        cur_req = "R5"; bc(3, 21, 0); cycle();
        cur_req = "R4"; bc(1, 21, 1); cycle();
        // cycle 6 idle: R6 slow allocation
        cur_req = "R6"; alloc(3, 30, 31, 0, 0, 1); cycle();
        cur_req = "R6"; cycle();
        // cycle 8 idle: producers broadcast only now; no change at this edge
        cur_req = "R6"; bc(0, 30, 1); bc(1, 31, 1); cycle();
        // cycle 9 active: replay from held broadcast makes it ready
        cur_req = "R7"; cycle();
        // R8 release, then allocate and release the same slot together
        cur_req = "R8"; s_dv = 1; s_di = 0; cycle();
        cur_req = "R8"; alloc(1, 40, 41, 0, 0, 0); s_dv = 1; s_di = 1; cycle();
        // R9 flags remain set over idle cycles
        cur_req = "R9"; repeat (4) cycle();

        // random mix with a small tag space
        cur_req = "R7";
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 3) == 0)
                alloc($urandom_range(0, N - 1), $urandom_range(0, 11),
                      $urandom_range(0, 11), ($urandom_range(0, 4) == 0),
                      ($urandom_range(0, 4) == 0), $urandom_range(0, 1));
            if ($urandom_range(0, 4) == 0) begin
                s_dv = 1; s_di = IXW'($urandom_range(0, N - 1));
            end
            for (int i = 0; i < IW; i++)
                if ($urandom_range(0, 3) == 0) bc(i, $urandom_range(0, 11), $urandom_range(0, 1));
            cycle();
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule